// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block produces a signed frequency-offset word once per reference-clock tick. The word steers a fractional-N divider or a numerically controlled oscillator so that the synthesized clock is swept slowly up and down in frequency. Sweeping the clock this way spreads its energy over a wider band and lowers the peak emission. The sweep follows a triangle. The offset falls linearly from its upper extreme to its lower extreme over one half of the modulation period, then climbs back over the other half. Every offset in the range therefore gets the same dwell time.

Two placements of the sweep are available. In down-spread, the whole excursion lies at or below nominal, so no synthesized period is ever shorter than the unmodulated one. In center-spread, the excursion is symmetric about nominal, so the mean frequency stays at nominal. The spread depth and the modulation period are given in offset LSBs and in reference ticks. This lets the sweep be set to the smallest depth that meets the emission target, at a rate near 32 kHz from the available reference. A new setting takes effect only at the start of a triangle, so a ramp is never broken mid-way. When the block is disabled, the offset is zero.

Top module: `spread_tri_mod`

## Requirements
- R1: While `en_i` is low, and on every tick following a tick on which it was sampled low, `offset_o` is 0 and `dir_up_o` and `wrap_o` are 0.
- R2: On the first tick after `en_i` is sampled high while idle, `offset_o` equals the upper extreme of the sampled setting. That extreme is 0 for down-spread (`center_i`=0) and floor(depth/2) for center-spread (`center_i`=1).
- R3: The half period is H = max(floor(`period_i`/2), 2), and one triangle lasts exactly 2H ticks. Positions in the triangle are numbered k = 0 .. 2H-1, and `wrap_o` is high for exactly one tick, at k = 2H-1.
- R4: Let span = depth for down-spread and 2*floor(depth/2) for center-spread. The step is S = floor(span*256/H), in units of 1/256 LSB. At position k < H, `offset_o` = floor((top*256 - k*S)/256). At position k >= H, `offset_o` = floor((low*256 + (k-H)*S)/256).
- R5: In down-spread, `offset_o` stays within [-depth, 0] and equals exactly -depth at k = H.
- R6: In center-spread, `offset_o` stays within [-floor(depth/2), +floor(depth/2)]. The sum of `offset_o` over one full triangle lies within [-H, +H].
- R7: `dir_up_o` is 1 exactly at positions k >= H of a running triangle. While it stays 1, `offset_o` never decreases.
- R8: Mode, depth and period are sampled only on the tick that starts a triangle, meaning the first tick after enabling or the tick after `wrap_o`. Any change in between has no effect on `offset_o` until that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Modulation enable |
| center_i | input | 1 | 0 = down-spread, 1 = center-spread |
| depth_i | input | OFS_W-1 | Spread depth in offset LSBs |
| period_i | input | PER_W | Triangle period in reference ticks |
| offset_o | output | OFS_W | Signed frequency-offset word |
| dir_up_o | output | 1 | High on the rising leg of the triangle |
| wrap_o | output | 1 | One-tick strobe on the last tick of each triangle |

## Verification
The assertions rely on several properties of the inputs. The depth must fit in OFS_W-1 bits, so that both extremes and the fractional accumulator stay representable. The period must yield a half period of at least two ticks. The assertions also allow setting changes on any tick, because they are written against the latched setting and not the live inputs. The stimulus draws depth, mode and period from $urandom with a fixed seed, and keeps depth below 2^(OFS_W-1). It includes odd and tiny periods that exercise the minimum half period, zero depth, and a period near 32 kHz at the 250 MHz reference. It also changes the setting and toggles the enable in the middle of a ramp.

// File: rtl/spread_pkg.sv
package spread_pkg;
  typedef enum logic {
    SPREAD_DOWN   = 1'b0,
    SPREAD_CENTER = 1'b1
  } spread_mode_e;

  localparam int unsigned MIN_HALF = 2;
endpackage

// File: rtl/spread_extremes.sv
// Upper/lower extremes and total excursion for a requested setting.
module spread_extremes
  import spread_pkg::*;
#(
  parameter int unsigned OFS_W   = 16,
  localparam int unsigned DEPTH_W = OFS_W - 1
) (
  input  spread_mode_e             mode_i,
  input  logic [DEPTH_W-1:0]       depth_i,
  output logic signed [OFS_W-1:0]  top_o,
  output logic signed [OFS_W-1:0]  low_o,
  output logic [OFS_W-1:0]         span_o
);
  logic [OFS_W-1:0] half_depth;
  logic [OFS_W-1:0] full_depth;

  assign half_depth = {2'b00, depth_i[DEPTH_W-1:1]};
  assign full_depth = {1'b0, depth_i};

  always_comb begin
    if (mode_i == SPREAD_CENTER) begin
      top_o  = $signed(half_depth);
      low_o  = -$signed(half_depth);
      span_o = {half_depth[OFS_W-2:0], 1'b0};
    end else begin
      top_o  = '0;
      low_o  = -$signed(full_depth);
      span_o = full_depth;
    end
  end
endmodule

// File: rtl/spread_step_div.sv
// Half period and per-tick fractional step for a requested setting.
module spread_step_div
  import spread_pkg::*;
#(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned ACC_W = OFS_W + FRAC_W
) (
  input  logic [OFS_W-1:0] span_i,
  input  logic [PER_W-1:0] period_i,
  output logic [PER_W-1:0] half_o,
  output logic [ACC_W-1:0] step_o
);
  logic [PER_W-1:0] raw_half;
  logic [ACC_W-1:0] numer;
  logic [ACC_W-1:0] denom;

  assign raw_half = {1'b0, period_i[PER_W-1:1]};
  assign half_o   = (raw_half < PER_W'(MIN_HALF)) ? PER_W'(MIN_HALF) : raw_half;
  assign numer    = {span_i, {FRAC_W{1'b0}}};
  assign denom    = ACC_W'(half_o);
  assign step_o   = numer / denom;
endmodule

// File: rtl/spread_ramp.sv
// Position counter, fractional ramp accumulator and latched setting.
module spread_ramp
  import spread_pkg::*;
#(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned ACC_W = OFS_W + FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  spread_mode_e            mode_i,
  input  logic signed [OFS_W-1:0] top_i,
  input  logic signed [OFS_W-1:0] low_i,
  input  logic [PER_W-1:0]        half_i,
  input  logic [ACC_W-1:0]        step_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    dir_up_o,
  output logic                    wrap_o,
  output spread_mode_e            mode_o,
  output logic signed [OFS_W-1:0] top_o,
  output logic signed [OFS_W-1:0] low_o
);
  logic                    run_q, run_d;
  logic [PER_W-1:0]        cnt_q, cnt_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0]        step_q;
  logic [PER_W-1:0]        half_q;
  logic signed [OFS_W-1:0] top_q, low_q;
  spread_mode_e            mode_q;

  logic                    last_tick;
  logic                    load;
  logic [PER_W-1:0]        cnt_inc;
  logic signed [ACC_W:0]   acc_move;
  logic signed [ACC_W:0]   top_fx, low_fx;

  assign last_tick = (cnt_q == ({half_q[PER_W-2:0], 1'b0} - PER_W'(1)));
  assign load      = en_i && (!run_q || last_tick);
  assign cnt_inc   = cnt_q + PER_W'(1);
  assign top_fx    = {top_q[OFS_W-1], top_q, {FRAC_W{1'b0}}};
  assign low_fx    = {low_q[OFS_W-1], low_q, {FRAC_W{1'b0}}};

  // next state
  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    acc_move = '0;
    if (!en_i) begin
      run_d = 1'b0;
      cnt_d = '0;
      acc_d = '0;
    end else if (load) begin
      run_d = 1'b1;
      cnt_d = '0;
      acc_d = {top_i, {FRAC_W{1'b0}}};
    end else begin
      cnt_d = cnt_inc;
      if (cnt_inc == half_q) begin
        acc_move = low_fx;
      end else if (cnt_inc < half_q) begin
        acc_move = {acc_q[ACC_W-1], acc_q} - $signed({1'b0, step_q});
      end else begin
        acc_move = {acc_q[ACC_W-1], acc_q} + $signed({1'b0, step_q});
      end
      if (acc_move < low_fx)      acc_d = low_fx[ACC_W-1:0];
      else if (acc_move > top_fx) acc_d = top_fx[ACC_W-1:0];
      else                        acc_d = acc_move[ACC_W-1:0];
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      half_q <= PER_W'(MIN_HALF);
      top_q  <= '0;
      low_q  <= '0;
      mode_q <= SPREAD_DOWN;
    end else if (load) begin
      step_q <= step_i;
      half_q <= half_i;
      top_q  <= top_i;
      low_q  <= low_i;
      mode_q <= mode_i;
    end
  end

  assign offset_o = acc_q[ACC_W-1:FRAC_W];
  assign dir_up_o = run_q && (cnt_q >= half_q);
  assign wrap_o   = run_q && last_tick;
  assign mode_o   = mode_q;
  assign top_o    = top_q;
  assign low_o    = low_q;

  // R1
  dis_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (offset_o == '0) && !dir_up_o && !wrap_o);

  // R2
  start_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (offset_o == top_q));

  // R3
  wrap_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && run_q && !$past(wrap_o)) |->
      ($stable(step_q) && $stable(half_q) && $stable(low_q) && $stable(top_q)));
endmodule

// File: rtl/spread_tri_mod.sv
module spread_tri_mod
  import spread_pkg::*;
#(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned FRAC_W = 8,
  localparam int unsigned DEPTH_W = OFS_W - 1,
  localparam int unsigned ACC_W   = OFS_W + FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    center_i,
  input  logic [DEPTH_W-1:0]      depth_i,
  input  logic [PER_W-1:0]        period_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    dir_up_o,
  output logic                    wrap_o
);
  spread_mode_e            mode_in, mode_q;
  logic signed [OFS_W-1:0] top_in, low_in, top_q, low_q;
  logic [OFS_W-1:0]        span_in;
  logic [PER_W-1:0]        half_in;
  logic [ACC_W-1:0]        step_in;

  assign mode_in = center_i ? SPREAD_CENTER : SPREAD_DOWN;

  spread_extremes #(.OFS_W(OFS_W)) i_extremes (
    .mode_i  (mode_in),
    .depth_i (depth_i),
    .top_o   (top_in),
    .low_o   (low_in),
    .span_o  (span_in)
  );

  spread_step_div #(.OFS_W(OFS_W), .PER_W(PER_W), .FRAC_W(FRAC_W)) i_step_div (
    .span_i   (span_in),
    .period_i (period_i),
    .half_o   (half_in),
    .step_o   (step_in)
  );

  spread_ramp #(.OFS_W(OFS_W), .PER_W(PER_W), .FRAC_W(FRAC_W)) i_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mode_i   (mode_in),
    .top_i    (top_in),
    .low_i    (low_in),
    .half_i   (half_in),
    .step_i   (step_in),
    .offset_o (offset_o),
    .dir_up_o (dir_up_o),
    .wrap_o   (wrap_o),
    .mode_o   (mode_q),
    .top_o    (top_q),
    .low_o    (low_q)
  );

  // R5
  down_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SPREAD_DOWN) |-> (offset_o <= 0) && (offset_o >= low_q));

  // R6
  center_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SPREAD_CENTER) |-> (offset_o <= top_q) && (offset_o >= -top_q));

  // R7
  rise_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_up_o && $past(dir_up_o)) |-> (offset_o >= $past(offset_o)));
endmodule

// File: tb/test_spread_tri_mod.sv
`timescale 1ns/1ps
module test_spread_tri_mod;
  localparam int OFS_W = 16;
  localparam int PER_W = 16;
  localparam int FRAC  = 8;
  localparam int DEPTH_W = OFS_W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic center = 1'b0;
  logic [DEPTH_W-1:0] depth = '0;
  logic [PER_W-1:0] period = 16'd20;
  logic signed [OFS_W-1:0] offset;
  logic dir_up, wrap;

  always #2 clk = ~clk;

  spread_tri_mod #(.OFS_W(OFS_W), .PER_W(PER_W), .FRAC_W(FRAC)) i_spread_tri_mod (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .center_i(center),
    .depth_i(depth), .period_i(period),
    .offset_o(offset), .dir_up_o(dir_up), .wrap_o(wrap)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R4";

  // bench model state
  bit     m_run = 0;
  longint m_k = 0, m_h = 2, m_top = 0, m_low = 0, m_step = 0, m_depth = 0;
  bit     m_center = 0;
  longint psum = 0, plen = 0;
  bit     pvalid = 0;

  function automatic longint half_of(longint p);
    longint h = p / 2;
    return (h < 2) ? 2 : h;
  endfunction

  function automatic longint expect_off();
    longint v;
    if (!m_run) return 0;
    if (m_k < m_h) v = m_top * 256 - m_k * m_step;
    else           v = m_low * 256 + (m_k - m_h) * m_step;
    return v >>> FRAC;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    longint span, d;
    if (!en) begin
      m_run = 0; m_k = 0;
    end else if (!m_run || m_k == 2 * m_h - 1) begin
      d = longint'(depth);
      m_center = center;
      m_depth = d;
      m_h = half_of(longint'(period));
      if (center) begin m_top = d / 2; m_low = -(d / 2); span = 2 * (d / 2); end
      else        begin m_top = 0;     m_low = -d;       span = d; end
      m_step = (span * 256) / m_h;
      m_k = 0; m_run = 1;
    end else begin
      m_k++;
    end
  endtask

  task automatic cyc();
    longint o, e;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    o = longint'(offset);
    e = expect_off();
    check(o == e, m_run ? tag : "R1", o, e);
    check(dir_up == (m_run && m_k >= m_h), "R7", longint'(dir_up), longint'(m_run && m_k >= m_h));
    check(wrap == (m_run && m_k == 2 * m_h - 1), "R3", longint'(wrap), longint'(m_run && m_k == 2 * m_h - 1));
    if (m_run) begin
      if (!m_center) begin
        check(o <= 0 && o >= -m_depth, "R5", o, -m_depth);
        if (m_k == m_h) check(o == -m_depth, "R5", o, -m_depth);
      end else begin
        check(o <= m_top && o >= -m_top, "R6", o, m_top);
      end
      if (m_k == 0) begin
        pvalid = 1; psum = 0; plen = 0;
      end
      if (pvalid) begin
        psum += o; plen++;
        if (wrap) begin
          check(plen == 2 * m_h, "R3", plen, 2 * m_h);
          if (m_center) check(psum <= m_h && psum >= -m_h, "R6", psum, 0);
          pvalid = 0;
        end
      end
    end else begin
      pvalid = 0;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic setup(bit c, int d, int p);
    center = c; depth = DEPTH_W'(d); period = PER_W'(p);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : stim
    int dummy;
    dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc();
    check(offset == 0 && !dir_up && !wrap, "R1", longint'(offset), 0);

    // R2, R5: down-spread, first tick at top, bottom at k=H
    setup(0, 100, 20);
    en = 1;
    cyc();
    check(longint'(offset) == 0, "R2", longint'(offset), 0);
    run(45);

    // R1: disable mid-ramp
    en = 0;
    cyc();
    check(offset == 0, "R1", longint'(offset), 0);
    run(3);

    // R2, R6: center-spread odd depth
    setup(1, 201, 16);
    en = 1;
    cyc();
    check(longint'(offset) == 100, "R2", longint'(offset), 100);
    run(40);
    en = 0; cyc();

    // R3: odd period and minimum half period
    setup(1, 64, 15); en = 1; run(30); en = 0; cyc();
    setup(0, 37, 1);  en = 1; run(12); en = 0; cyc();
    setup(1, 0, 10);  en = 1; run(22); en = 0; cyc();

    // R8: setting changed mid-triangle takes effect only after wrap
    tag = "R8";
    setup(1, 200, 40); en = 1; run(6);
    setup(0, 50, 12);  run(80);
    tag = "R4";
    en = 0; cyc();

    // R4: near 32 kHz at 250 MHz reference, about 2 percent of a 2^15 scale
    setup(0, 655, 7812); en = 1; run(2 * 7812 + 4); en = 0; cyc();

    // R4: constrained random settings, mid-ramp changes and enable toggles
    for (int r = 0; r < 40; r++) begin
      setup($urandom_range(0, 1), $urandom_range(0, 32767), $urandom_range(1, 300));
      en = 1;
      for (int t = 0; t < 500; t++) begin
        cyc();
        if ($urandom_range(0, 99) == 0)
          setup($urandom_range(0, 1), $urandom_range(0, 32767), $urandom_range(1, 300));
        if ($urandom_range(0, 299) == 0) begin
          en = 0; cyc(); en = 1;
        end
      end
    end
    en = 0; run(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule